// File: doc/BRIEF.md
# Transmit Command Word Packet Builder

This block sits behind a host-written transmit data port. The host writes a stream of 32-bit words. Each buffer opens with a header word that gives the buffer's byte count, a starting byte offset, an end-padding rule, segment flags and an interrupt request. A second header word then follows. On the first segment of a packet, that second word carries a 16-bit packet tag in its upper half. The block removes the words and bytes that are only there for host-side alignment: whole words skipped at the start, low bytes dropped from the first payload word, and padding words at the end. It then presents the payload as byte lanes, least significant lane first.

A packet may be built from several buffers. When a buffer marked as the last segment ends, the block pulses a send strobe. It also tells a status-queue tracker to push the packet tag, as long as the queue has room. The block counts the words that occupy the data FIFO. A write that arrives while that count is at capacity raises a sticky overflow flag and is otherwise dropped. A synchronous clear returns the parser to waiting for a header word.

Top module: `txcmd_packer`

## Requirements
- R1: After `rst`, the outputs `out_valid`, `out_last`, `tx_send`, `tx_ioc`, `stat_push`, `ovf_flag` and `stat_full` are all 0.
- R2: The first word of a buffer (header A) is kept masked with 0x831F37FF. Its fields are: bits 10:0 the buffer byte count, bits 20:16 the start offset in bytes, bit 12 last segment, bit 13 first segment, bits 25:24 the padding mode, and bit 31 the completion interrupt request.
- R3: When header A has bit 13 set, the next word is header B, and its bits 31:16 become the packet tag. When bit 13 is clear, the next word is consumed and discarded, and the tag keeps its earlier value.
- R4: While the remaining start offset is 4 or more, each data word is discarded with no output, and the offset drops by 4. A remaining offset of 1 to 3 drops that many low bytes from the next word.
- R5: Payload bytes leave a data word least significant byte first. On each payload beat, `out_valid` is 1, the bytes sit packed from `out_data[7:0]` upward, unused lanes are 0, and `out_nbytes` (0 to 4) gives their count. Output appears on the clock edge that accepts the word.
- R6: Once the byte count is used up, the block consumes and drops padding words without output. Let W = ceil((count + offset) / 4). With padding mode 1 the pad is (−W) mod 4 words. With mode 2 it is (−W) mod 8 words. Modes 0 and 3 add no padding.
- R7: A buffer ends on the word that leaves both the byte count and the pad at zero. The block then returns to expecting header A. It pulses `tx_send` if bit 12 was set, and pulses `tx_ioc` if bit 31 was set. `out_last` marks a payload beat that ends a sent packet.
- R8: On a send, `stat_push` pulses with `stat_tag` equal to the packet tag, but only if the status occupancy, taken before any pop in the same cycle, is below STAT_DEPTH. A `stat_pop` lowers the occupancy when it is nonzero. `stat_full` is set, and stays set, when a push brings the occupancy to STAT_DEPTH.
- R9: The used-word count increments on header A, on header B of a first segment, and on each payload word. It returns to 0 on a send. A write while the count equals DATA_WORDS sets the sticky `ovf_flag` and produces no output.
- R10: `clr` has priority over a write in the same cycle. It returns the parser to expecting header A, sets header A to all ones and zeroes the used-word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous parser clear |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host word |
| stat_pop | input | 1 | Status consumer removes one entry |
| out_valid | output | 1 | Payload beat present |
| out_data | output | 32 | Payload bytes, packed from lane 0 |
| out_nbytes | output | 3 | Number of valid bytes in the beat |
| out_last | output | 1 | Beat ends a sent packet |
| tx_send | output | 1 | Packet send pulse |
| tx_ioc | output | 1 | Completion interrupt pulse |
| ovf_flag | output | 1 | Sticky data-FIFO overflow |
| stat_push | output | 1 | Status entry push pulse |
| stat_tag | output | 16 | Tag carried by the push |
| stat_full | output | 1 | Sticky status-queue full |

## Verification
A packet send and a consumer pop can fall in the same cycle, so the status-queue decision has to be made on the occupancy before the pop. The bench provokes this case twice. First it pops in the cycle of a send while the queue holds one entry less than full: the push must happen and `stat_full` must stay low. Then it pops in the cycle of a send while the queue is completely full: no push must happen, yet the next send must push, which shows the pop took effect. The expected pushes and the full flag come from an occupancy the bench works out itself. A sweep over byte counts, start offsets and padding modes compares every emitted byte, and the word on which the send occurs, with values the bench computes.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMDB = 2'd1,
        ST_DATA = 2'd2
    } prs_state_e;

    localparam logic [31:0] CMDA_KEEP = 32'h831F_37FF;

    typedef struct packed {
        logic        ioc;
        logic [1:0]  pad_mode;
        logic [4:0]  start_off;
        logic        first_seg;
        logic        last_seg;
        logic [10:0] byte_cnt;
    } cmda_t;

    function automatic cmda_t cmda_decode(input logic [31:0] w);
        cmda_t r;
        r.ioc       = w[31];
        r.pad_mode  = w[25:24];
        r.start_off = w[20:16];
        r.first_seg = w[13];
        r.last_seg  = w[12];
        r.byte_cnt  = w[10:0];
        return r;
    endfunction

    // number of trailing pad words for a buffer
    function automatic logic [2:0] pad_words(input logic [1:0]  mode,
                                             input logic [10:0] cnt,
                                             input logic [4:0]  off);
        logic [12:0] words;
        logic [12:0] neg;
        words = ({2'b00, cnt} + {8'd0, off} + 13'd3) >> 2;
        neg   = 13'd0 - words;
        case (mode)
            2'b01:   return {1'b0, neg[1:0]};
            2'b10:   return neg[2:0];
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/txcmd_lanes.sv
module txcmd_lanes (
    input  logic [31:0] word_i,
    input  logic [1:0]  drop_i,
    input  logic [10:0] remain_i,
    output logic [31:0] data_o,
    output logic [2:0]  take_o
);
    localparam int LANES = 4;

    logic [12:0] avail;
    logic [2:0]  total;
    logic [31:0] shifted;

    always_comb begin
        avail   = {2'b00, remain_i} + {11'd0, drop_i};
        total   = (avail >= 13'd4) ? 3'd4 : avail[2:0];
        take_o  = total - {1'b0, drop_i};
        shifted = word_i >> {drop_i, 3'b000};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data_o[8*g +: 8] = (3'(g) < take_o) ? shifted[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/txcmd_parser.sv
module txcmd_parser
    import txcmd_pkg::*;
#(
    parameter int DATA_WORDS = 4608
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        out_valid_o,
    output logic [31:0] out_data_o,
    output logic [2:0]  out_nbytes_o,
    output logic        out_last_o,
    output logic        tx_send_o,
    output logic        tx_ioc_o,
    output logic        ovf_o,
    output logic        send_now_o,
    output logic [15:0] tag_now_o
);
    localparam int UW = $clog2(DATA_WORDS + 1);
    localparam logic [UW-1:0] USED_MAX = UW'(DATA_WORDS);

    prs_state_e  st_q, st_n;
    cmda_t       ca_q, ca_n, hdr_in;
    logic [15:0] tag_q, tag_n;
    logic [10:0] rem_q, rem_n;
    logic [4:0]  off_q, off_n;
    logic [2:0]  pad_q, pad_n;
    logic [UW-1:0] used_q, used_n;
    logic        ovf_q, ovf_n;
    logic        beat_c, last_c, send_c, ioc_c, end_c;
    logic [31:0] lane_data;
    logic [2:0]  lane_take;

    txcmd_lanes u_lanes (
        .word_i   (wr_data),
        .drop_i   (off_q[1:0]),
        .remain_i (rem_q),
        .data_o   (lane_data),
        .take_o   (lane_take)
    );

    assign hdr_in = cmda_decode(wr_data & CMDA_KEEP);

    always_comb begin
        st_n   = st_q;
        ca_n   = ca_q;
        tag_n  = tag_q;
        rem_n  = rem_q;
        off_n  = off_q;
        pad_n  = pad_q;
        used_n = used_q;
        ovf_n  = ovf_q;
        beat_c = 1'b0;
        last_c = 1'b0;
        send_c = 1'b0;
        ioc_c  = 1'b0;
        end_c  = 1'b0;
        if (clr) begin
            st_n   = ST_IDLE;
            ca_n   = '1;
            used_n = '0;
        end else if (wr_en) begin
            if (used_q == USED_MAX) begin
                ovf_n = 1'b1;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        ca_n   = hdr_in;
                        rem_n  = hdr_in.byte_cnt;
                        off_n  = hdr_in.start_off;
                        used_n = used_q + UW'(1);
                        st_n   = ST_CMDB;
                    end
                    ST_CMDB: begin
                        if (ca_q.first_seg) begin
                            tag_n  = wr_data[31:16];
                            used_n = used_q + UW'(1);
                            pad_n  = pad_words(ca_q.pad_mode, rem_q, off_q);
                        end
                        st_n = ST_DATA;
                    end
                    ST_DATA: begin
                        if (off_q >= 5'd4) begin
                            off_n = off_q - 5'd4;
                        end else begin
                            if (rem_q == 11'd0 && pad_q != 3'd0) begin
                                pad_n = pad_q - 3'd1;
                            end else begin
                                beat_c = 1'b1;
                                rem_n  = rem_q - {8'd0, lane_take};
                                off_n  = 5'd0;
                                used_n = used_q + UW'(1);
                            end
                            end_c = (rem_n == 11'd0) && (pad_n == 3'd0);
                            if (end_c) begin
                                st_n = ST_IDLE;
                                if (ca_q.last_seg) begin
                                    send_c = 1'b1;
                                    used_n = '0;
                                end
                                ioc_c  = ca_q.ioc;
                                last_c = beat_c && ca_q.last_seg;
                            end
                        end
                    end
                    default: st_n = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            ca_q         <= '1;
            tag_q        <= '0;
            rem_q        <= '0;
            off_q        <= '0;
            pad_q        <= '0;
            used_q       <= '0;
            ovf_q        <= 1'b0;
            out_valid_o  <= 1'b0;
            out_data_o   <= '0;
            out_nbytes_o <= '0;
            out_last_o   <= 1'b0;
            tx_send_o    <= 1'b0;
            tx_ioc_o     <= 1'b0;
        end else begin
            st_q         <= st_n;
            ca_q         <= ca_n;
            tag_q        <= tag_n;
            rem_q        <= rem_n;
            off_q        <= off_n;
            pad_q        <= pad_n;
            used_q       <= used_n;
            ovf_q        <= ovf_n;
            out_valid_o  <= beat_c;
            out_data_o   <= beat_c ? lane_data : '0;
            out_nbytes_o <= beat_c ? lane_take : '0;
            out_last_o   <= last_c;
            tx_send_o    <= send_c;
            tx_ioc_o     <= ioc_c;
        end
    end

    assign ovf_o      = ovf_q;
    assign send_now_o = send_c;
    assign tag_now_o  = tag_q;

    // R9: a write at capacity produces nothing and leaves the overflow flag set
    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr && used_q == USED_MAX) |=> (!out_valid_o && !tx_send_o && ovf_o));

    a_r9_used_bounded: assert property (@(posedge clk) disable iff (rst)
        used_q <= USED_MAX);

    a_r4_skip_word_silent: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr && st_q == ST_DATA && off_q >= 5'd4 && used_q != USED_MAX)
        |=> (!out_valid_o && !tx_send_o));

    a_r6_pad_word_silent: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr && st_q == ST_DATA && off_q < 5'd4 && rem_q == 11'd0 &&
         pad_q != 3'd0 && used_q != USED_MAX) |=> !out_valid_o);

    a_r7_send_returns_idle: assert property (@(posedge clk) disable iff (rst)
        tx_send_o |-> (st_q == ST_IDLE));

    a_r10_clear_idle: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q == ST_IDLE && used_q == '0));

endmodule

// File: rtl/txcmd_stat.sv
module txcmd_stat #(
    parameter int DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        send_i,
    input  logic [15:0] tag_i,
    input  logic        pop_i,
    output logic        push_o,
    output logic [15:0] tag_o,
    output logic        full_o
);
    localparam int SW = $clog2(DEPTH + 1);
    localparam logic [SW-1:0] OCC_MAX = SW'(DEPTH);

    logic [SW-1:0] occ_q, occ_n;
    logic          room_c, pop_eff, push_c;

    always_comb begin
        room_c  = (occ_q != OCC_MAX);
        pop_eff = pop_i && (occ_q != '0);
        push_c  = send_i && room_c;
        occ_n   = occ_q;
        if (push_c && !pop_eff) occ_n = occ_q + SW'(1);
        else if (!push_c && pop_eff) occ_n = occ_q - SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q  <= '0;
            push_o <= 1'b0;
            tag_o  <= '0;
            full_o <= 1'b0;
        end else begin
            occ_q  <= occ_n;
            push_o <= push_c;
            tag_o  <= push_c ? tag_i : tag_o;
            if (push_c && occ_n == OCC_MAX) full_o <= 1'b1;
        end
    end

    // R8: no push when the queue was already full before the cycle's pop
    a_r8_full_blocks_push: assert property (@(posedge clk) disable iff (rst)
        (send_i && occ_q == OCC_MAX) |=> !push_o);

    a_r8_occ_bounded: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OCC_MAX);

    a_r8_full_raised: assert property (@(posedge clk) disable iff (rst)
        (send_i && !pop_eff && occ_q == OCC_MAX - SW'(1)) |=> (full_o && push_o));

endmodule

// File: rtl/txcmd_packer.sv
module txcmd_packer #(
    parameter int DATA_WORDS = 4608,
    parameter int STAT_DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        stat_pop,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic [2:0]  out_nbytes,
    output logic        out_last,
    output logic        tx_send,
    output logic        tx_ioc,
    output logic        ovf_flag,
    output logic        stat_push,
    output logic [15:0] stat_tag,
    output logic        stat_full
);
    logic        send_now;
    logic [15:0] tag_now;

    txcmd_parser #(.DATA_WORDS(DATA_WORDS)) u_parser (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .out_valid_o  (out_valid),
        .out_data_o   (out_data),
        .out_nbytes_o (out_nbytes),
        .out_last_o   (out_last),
        .tx_send_o    (tx_send),
        .tx_ioc_o     (tx_ioc),
        .ovf_o        (ovf_flag),
        .send_now_o   (send_now),
        .tag_now_o    (tag_now)
    );

    txcmd_stat #(.DEPTH(STAT_DEPTH)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .send_i (send_now),
        .tag_i  (tag_now),
        .pop_i  (stat_pop),
        .push_o (stat_push),
        .tag_o  (stat_tag),
        .full_o (stat_full)
    );

    // R7: a send pulse and the status push come from the same accepted word
    a_r7_push_needs_send: assert property (@(posedge clk) disable iff (rst)
        stat_push |-> tx_send);

endmodule

// File: tb/test_txcmd_packer.sv
module test_txcmd_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        stat_pop = 1'b0;
    logic        out_valid, out_last, tx_send, tx_ioc, ovf_flag, stat_push, stat_full;
    logic [31:0] out_data;
    logic [2:0]  out_nbytes;
    logic [15:0] stat_tag;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] got [0:63];
    int gn;
    logic s_valid, s_last, s_send, s_ioc, s_push, s_full, s_ovf;
    logic [2:0]  s_nb;
    logic [15:0] s_tag;

    always #4 clk = ~clk;

    txcmd_packer #(.DATA_WORDS(16), .STAT_DEPTH(4)) i_txcmd_packer (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .stat_pop(stat_pop), .out_valid(out_valid), .out_data(out_data),
        .out_nbytes(out_nbytes), .out_last(out_last), .tx_send(tx_send),
        .tx_ioc(tx_ioc), .ovf_flag(ovf_flag), .stat_push(stat_push),
        .stat_tag(stat_tag), .stat_full(stat_full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit we, input logic [31:0] w, input bit pop, input bit cl);
        @(negedge clk);
        wr_en = we; wr_data = w; stat_pop = pop; clr = cl;
        @(posedge clk);
        #1;
        wr_en = 1'b0; stat_pop = 1'b0; clr = 1'b0;
        s_valid = out_valid; s_last = out_last; s_send = tx_send; s_ioc = tx_ioc;
        s_push = stat_push; s_tag = stat_tag; s_full = stat_full; s_ovf = ovf_flag;
        s_nb = out_nbytes;
        if (out_valid) begin
            for (int b = 0; b < 4; b++) begin
                if (b < int'(out_nbytes) && gn < 64) begin
                    got[gn] = out_data[8*b +: 8];
                    gn++;
                end
            end
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed) & 255);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // sweep packet: first+last segment, checks bytes, pad, send, ioc, status
    task automatic run_packet(input int len, input int off, input int pm, input logic [15:0] tag);
        int words, pad, total, sends, send_at, lasts, iocs, pushes, mism;
        logic [15:0] ptag;
        logic [31:0] w;
        logic [31:0] ca;
        int ioc;
        ioc = len & 1;
        words = (len + off + 3) / 4;
        pad = (pm == 1) ? ((4 - words % 4) % 4) : (pm == 2) ? ((8 - words % 8) % 8) : 0;
        total = words + pad;
        ca = (32'(ioc) << 31) | (32'(pm) << 24) | (32'(off) << 16) | 32'h3000 | 32'(len);
        gn = 0; sends = 0; send_at = -1; lasts = 0; iocs = 0; pushes = 0; ptag = '0;
        cyc(1'b1, ca, 1'b0, 1'b0);
        cyc(1'b1, {tag, 16'h5A5A}, 1'b0, 1'b0);
        for (int k = 0; k < total; k++) begin
            w = 32'hEEEE_EEEE;
            if (k < words) begin
                for (int b = 0; b < 4; b++) begin
                    int p;
                    p = 4 * k + b;
                    if (p >= off && p < off + len) w[8*b +: 8] = pat(p - off, int'(tag[7:0]));
                end
            end
            cyc(1'b1, w, 1'b0, 1'b0);
            if (s_send) begin sends++; send_at = k; end
            if (s_last) lasts++;
            if (s_ioc) iocs++;
            if (s_push) begin pushes++; ptag = s_tag; end
        end
        mism = 0;
        for (int i = 0; i < len && i < 64; i++) if (got[i] !== pat(i, int'(tag[7:0]))) mism++;
        chk(mism == 0 && gn == len, "R5 R4 payload bytes", 32'(gn), 32'(len));
        chk(sends == 1 && send_at == total - 1, "R7 R6 send on final word", 32'(send_at), 32'(total - 1));
        chk(lasts == ((pad == 0) ? 1 : 0), "R6 last flag on payload beat", 32'(lasts), 32'((pad == 0) ? 1 : 0));
        chk(iocs == ioc, "R2 R7 completion interrupt", 32'(iocs), 32'(ioc));
        chk(pushes == 1 && ptag == tag, "R8 R3 status tag", {16'(pushes), ptag}, {16'd1, tag});
        cyc(1'b0, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic mini_packet(input logic [15:0] tag, input bit pop_on_data);
        cyc(1'b1, 32'h0000_3004, 1'b0, 1'b0);
        cyc(1'b1, {tag, 16'h0}, 1'b0, 1'b0);
        cyc(1'b1, 32'h4433_2211, pop_on_data, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got %0d exp %0d", nchk, 0);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1 reset state
        chk({out_valid, out_last, tx_send, tx_ioc, stat_push, ovf_flag, stat_full} == 7'd0,
            "R1 reset outputs", 32'({out_valid, out_last, tx_send, tx_ioc, stat_push, ovf_flag, stat_full}), 32'd0);

        // sweep: byte count x start offset x padding mode
        for (int len = 1; len <= 24; len++)
            for (int off = 0; off < 8; off++)
                for (int pm = 0; pm < 4; pm++)
                    run_packet(len, off, pm, 16'((len << 8) | (off << 4) | pm));

        // R3 multi-segment: second word of a non-first segment is discarded
        gn = 0;
        cyc(1'b1, 32'h8002_2005, 1'b0, 1'b0);
        cyc(1'b1, 32'hBEEF_0008, 1'b0, 1'b0);
        cyc(1'b1, 32'hA1A0_EEEE, 1'b0, 1'b0);
        chk(!s_send && !s_ioc, "R7 no end mid buffer", {s_send, s_ioc}, 0);
        cyc(1'b1, 32'hEEA4_A3A2, 1'b0, 1'b0);
        chk(s_ioc && !s_send && !s_push, "R7 first segment ends without send", {s_ioc, s_send, s_push}, 32'h4);
        cyc(1'b1, 32'h0001_1003, 1'b0, 1'b0);
        cyc(1'b1, 32'h1234_5678, 1'b0, 1'b0);
        chk(!s_valid, "R3 discarded second word", 32'(s_valid), 0);
        cyc(1'b1, 32'hB2B1_B0EE, 1'b0, 1'b0);
        chk(s_send && s_last && s_push && s_tag == 16'hBEEF, "R3 tag kept across segments", {s_send, s_last, s_push, s_tag}, {3'b111, 16'hBEEF});
        chk(gn == 8 && got[0] == 8'hA0 && got[4] == 8'hA4 && got[5] == 8'hB0 && got[7] == 8'hB2,
            "R4 R5 multi-segment bytes", {got[0], got[4], got[5], got[7]}, 32'hA0A4B0B2);
        cyc(1'b0, 32'h0, 1'b1, 1'b0);

        // zero-length buffer: one payload word with no bytes ends it
        cyc(1'b1, 32'h0000_3000, 1'b0, 1'b0);
        cyc(1'b1, 32'h0777_0000, 1'b0, 1'b0);
        cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        chk(s_valid && s_nb == 3'd0 && s_send && s_last, "R7 zero byte buffer", {s_valid, s_nb, s_send, s_last}, {1'b1, 3'd0, 2'b11});

        // R8 status queue occupancy, with same-cycle pop collisions
        do_reset();
        mini_packet(16'h0001, 1'b0);
        mini_packet(16'h0002, 1'b0);
        mini_packet(16'h0003, 1'b0);
        chk(s_push && !s_full, "R8 three pushes not full", {s_push, s_full}, 32'h2);
        mini_packet(16'h0004, 1'b1);
        chk(s_push && !s_full && s_tag == 16'h0004, "R8 push with pop at depth-1", {s_push, s_full, s_tag}, {2'b10, 16'h0004});
        mini_packet(16'h0005, 1'b0);
        chk(s_push && s_full, "R8 full on reaching depth", {s_push, s_full}, 32'h3);
        mini_packet(16'h0006, 1'b0);
        chk(s_send && !s_push, "R8 no push when full", {s_send, s_push}, 32'h2);
        mini_packet(16'h0007, 1'b1);
        chk(s_send && !s_push, "R8 full before same-cycle pop", {s_send, s_push}, 32'h2);
        mini_packet(16'h0008, 1'b0);
        chk(s_push && s_tag == 16'h0008, "R8 pop freed one entry", {s_push, s_tag}, {1'b1, 16'h0008});

        // R9 used-word count and overflow
        do_reset();
        cyc(1'b1, 32'h0000_2064, 1'b0, 1'b0);
        cyc(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        for (int k = 0; k < 14; k++) cyc(1'b1, 32'h0101_0101, 1'b0, 1'b0);
        chk(!s_ovf && s_valid, "R9 no overflow below capacity", {s_ovf, s_valid}, 32'h1);
        cyc(1'b1, 32'h0202_0202, 1'b0, 1'b0);
        chk(s_ovf && !s_valid, "R9 write at capacity ignored", {s_ovf, s_valid}, 32'h2);

        // R10 clear returns to header A and frees the used count
        cyc(1'b0, 32'h0, 1'b0, 1'b1);
        gn = 0;
        mini_packet(16'h00C1, 1'b0);
        chk(s_send && gn == 4 && got[0] == 8'h11 && got[3] == 8'h44, "R10 parse after clear",
            {s_send, 8'(gn), got[0], got[3]}, {1'b1, 8'd4, 8'h11, 8'h44});
        chk(s_ovf, "R9 overflow flag sticky", 32'(s_ovf), 1);
        // clear mid-packet: the next word is again header A
        cyc(1'b1, 32'h0000_3010, 1'b0, 1'b0);
        cyc(1'b1, 32'h00D2_0000, 1'b0, 1'b0);
        cyc(1'b1, 32'h9999_9999, 1'b0, 1'b1);
        chk(!s_valid, "R10 clear beats write", 32'(s_valid), 0);
        gn = 0;
        mini_packet(16'h00D3, 1'b0);
        chk(s_send && gn == 4 && s_tag == 16'h00D3, "R10 clear mid packet", {s_send, 8'(gn), s_tag}, {1'b1, 8'd4, 16'h00D3});

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule